// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the start of each received frame and classifies its destination address, which is the first six bytes. It returns two flags: whether the frame should be kept, and whether its address missed the station's filters. The receive path uses these flags to drop the frame or store it, and to set a miss marker in its descriptor. Frame check sequence validation and buffer writing are done elsewhere.

The filters are checked in a fixed order, and the first one that applies decides the result. A broadcast address (all ones) is decided by a reject switch. A group address, or any address while hash-all mode is on, is looked up in a 64-entry hash table. The index for that lookup comes from a CRC-32 that is computed serially over the six address bytes as they arrive. Every other address must equal the station address exactly. The station address arrives as a 16-bit high word and a 32-bit low word. Promiscuous mode keeps frames that missed, but the miss flag is still reported for them.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, `res_valid`, `res_accept` and `res_miss` are all 0.
- R2: The result registers are written at the clock edge that samples the sixth address byte of a frame, where a byte is any cycle with `byte_valid` high. `res_valid` is then 1 from the next cycle. Idle cycles between bytes are allowed.
- R3: Once `res_valid` is 1, the result does not change until the next byte with `byte_sof` high. Bytes after the sixth, and bytes with no frame in progress, have no effect.
- R4: If all 48 address bits are 1, `res_miss` equals `mode_bcast_reject`.
- R5: A non-broadcast address uses the hash table if byte 0 bit 0 is 1 or if `mode_hash_all` is 1. The hash index is bits 31:26 of a CRC register. That register starts at all ones and shifts left once per address bit, taking the bits of each byte least significant first. At each shift, if the bit shifted out XOR the data bit is 1, the register is XORed with 0x04C11DB7. There is no final inversion. The frame misses when `hash_tbl[index]` is 0.
- R6: Any other address misses unless every byte matches. Byte 0 is compared with `stn_addr_hi[15:8]` and byte 1 with `stn_addr_hi[7:0]`. Bytes 2, 3, 4 and 5 are compared with `stn_addr_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R7: `res_accept` equals NOT `res_miss` OR `mode_promisc`. A frame accepted through promiscuous mode still shows `res_miss` = 1.
- R8: If `byte_eof` comes before the sixth byte, the result is written at that edge with `res_miss` = 1 and `res_accept` = `mode_promisc`.
- R9: A byte with `byte_sof` high always starts a new frame as byte 0. This holds even in the middle of a frame. `res_valid` is then 0 unless that same byte also ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A received byte is present this cycle |
| byte_sof | input | 1 | This byte is the first byte of a frame |
| byte_eof | input | 1 | This byte is the last byte of a frame |
| byte_data | input | 8 | Received byte |
| stn_addr_hi | input | 16 | Station address, bytes 0 and 1 |
| stn_addr_lo | input | 32 | Station address, bytes 2 to 5 |
| hash_tbl | input | 64 | Hash table; bit i is the entry for index i |
| mode_bcast_reject | input | 1 | A broadcast counts as a miss |
| mode_hash_all | input | 1 | Individual addresses also use the hash table |
| mode_promisc | input | 1 | Accept frames that miss |
| res_valid | output | 1 | Result is valid for the current frame |
| res_accept | output | 1 | Keep the frame |
| res_miss | output | 1 | The address missed all filters |

## Verification
The assertions assume two things about the inputs. `byte_sof` and `byte_eof` are only looked at while `byte_valid` is high. The mode bits and tables stay steady while a frame is being classified. The result-hold property also assumes that only a start-of-frame byte may disturb a finished result.

The stimulus keeps to these rules. It changes configuration only on idle cycles between frames, and it adds idle gaps inside frames. It also restarts one frame in the middle with a fresh start-of-frame byte. The monitor checks each result against the number of bytes sampled so far, so a result that arrives early or late fails as well as a wrong flag.

// File: rtl/eth_rx_addr_filter_pkg.sv
package eth_rx_addr_filter_pkg;
   localparam int ADDR_BYTES = 6;
   localparam int CRC_W      = 32;

   typedef logic [7:0] byte_t;
   typedef byte_t [ADDR_BYTES-1:0] dest_addr_t;

   // Advance a left-shifting CRC by one byte, least significant bit first.
   function automatic logic [CRC_W-1:0] crc_byte_step(
      input logic [CRC_W-1:0] crc_in,
      input byte_t            data,
      input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] c;
      logic             fb;
      c = crc_in;
      for (int b = 0; b < 8; b++) begin
         fb = c[CRC_W-1] ^ data[b];
         c  = {c[CRC_W-2:0], 1'b0};
         if (fb) c = c ^ poly;
      end
      return c;
   endfunction
endpackage

// File: rtl/eth_rx_addr_capture.sv
module eth_rx_addr_capture
   import eth_rx_addr_filter_pkg::*;
#(
   parameter int               HASH_W   = 6,
   parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic              byte_sof,
   input  logic              byte_eof,
   input  byte_t             byte_data,
   output logic              addr_last,
   output logic              short_end,
   output dest_addr_t        dest_addr,
   output logic [HASH_W-1:0] hash_idx
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

   initial begin
      assert (HASH_W >= 1 && HASH_W <= CRC_W)
         else $error("HASH_W out of range");
   end

   logic [CNT_W-1:0] cnt_q, idx;
   logic             done_q, first, active;
   logic [CRC_W-1:0] crc_q, crc_base, crc_nx;
   byte_t            slot_q [ADDR_BYTES-1];

   assign first     = byte_valid && byte_sof;
   assign idx       = first ? '0 : cnt_q;
   assign active    = byte_valid && (first || !done_q);
   assign crc_base  = first ? CRC_SEED : crc_q;
   assign crc_nx    = crc_byte_step(crc_base, byte_data, CRC_POLY);
   assign addr_last = active && (idx == LAST_IDX);
   assign short_end = active && byte_eof && (idx < LAST_IDX);
   assign hash_idx  = crc_nx[CRC_W-1 -: HASH_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b1;
         crc_q  <= CRC_SEED;
      end else if (active) begin
         cnt_q  <= idx + 1'b1;
         done_q <= addr_last || byte_eof;
         crc_q  <= crc_nx;
      end
   end

   genvar i;
   generate
      for (i = 0; i < ADDR_BYTES - 1; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[i] <= '0;
            else if (active && idx == CNT_W'(i))
               slot_q[i] <= byte_data;
         end
         assign dest_addr[i] = slot_q[i];
      end
   endgenerate
   assign dest_addr[ADDR_BYTES-1] = byte_data;

   // R2: the byte counter never passes the address length
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/eth_rx_addr_classify.sv
module eth_rx_addr_classify
   import eth_rx_addr_filter_pkg::*;
#(
   parameter int HASH_W = 6,
   localparam int TABLE_W = 1 << HASH_W
) (
   input  dest_addr_t         dest_addr,
   input  logic [HASH_W-1:0]  hash_idx,
   input  logic [15:0]        stn_addr_hi,
   input  logic [31:0]        stn_addr_lo,
   input  logic [TABLE_W-1:0] hash_tbl,
   input  logic               mode_bcast_reject,
   input  logic               mode_hash_all,
   output logic               miss
);
   dest_addr_t stn;
   logic [ADDR_BYTES-1:0] byte_eq;
   logic is_bcast, use_hash, hash_hit;

   assign stn[0] = stn_addr_hi[15:8];
   assign stn[1] = stn_addr_hi[7:0];
   assign stn[2] = stn_addr_lo[31:24];
   assign stn[3] = stn_addr_lo[23:16];
   assign stn[4] = stn_addr_lo[15:8];
   assign stn[5] = stn_addr_lo[7:0];

   genvar k;
   generate
      for (k = 0; k < ADDR_BYTES; k++) begin : g_cmp
         assign byte_eq[k] = (dest_addr[k] == stn[k]);
      end
   endgenerate

   assign is_bcast = &dest_addr;
   assign use_hash = dest_addr[0][0] || mode_hash_all;
   assign hash_hit = hash_tbl[hash_idx];

   always_comb begin
      if (is_bcast)      miss = mode_bcast_reject;
      else if (use_hash) miss = !hash_hit;
      else               miss = !(&byte_eq);
   end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
   import eth_rx_addr_filter_pkg::*;
#(
   parameter int               HASH_W   = 6,
   parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF,
   localparam int TABLE_W = 1 << HASH_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_valid,
   input  logic               byte_sof,
   input  logic               byte_eof,
   input  logic [7:0]         byte_data,
   input  logic [15:0]        stn_addr_hi,
   input  logic [31:0]        stn_addr_lo,
   input  logic [TABLE_W-1:0] hash_tbl,
   input  logic               mode_bcast_reject,
   input  logic               mode_hash_all,
   input  logic               mode_promisc,
   output logic               res_valid,
   output logic               res_accept,
   output logic               res_miss
);
   logic              addr_last, short_end, cls_miss;
   dest_addr_t        dest_addr;
   logic [HASH_W-1:0] hash_idx;

   eth_rx_addr_capture #(
      .HASH_W(HASH_W), .CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)
   ) u_capture (
      .clk(clk), .rst_n(rst_n),
      .byte_valid(byte_valid), .byte_sof(byte_sof), .byte_eof(byte_eof),
      .byte_data(byte_data),
      .addr_last(addr_last), .short_end(short_end),
      .dest_addr(dest_addr), .hash_idx(hash_idx)
   );

   eth_rx_addr_classify #(.HASH_W(HASH_W)) u_classify (
      .dest_addr(dest_addr), .hash_idx(hash_idx),
      .stn_addr_hi(stn_addr_hi), .stn_addr_lo(stn_addr_lo),
      .hash_tbl(hash_tbl),
      .mode_bcast_reject(mode_bcast_reject), .mode_hash_all(mode_hash_all),
      .miss(cls_miss)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_miss   <= 1'b0;
      end else if (addr_last) begin
         res_valid  <= 1'b1;
         res_miss   <= cls_miss;
         res_accept <= !cls_miss || mode_promisc;
      end else if (short_end) begin
         res_valid  <= 1'b1;
         res_miss   <= 1'b1;
         res_accept <= mode_promisc;
      end else if (byte_valid && byte_sof) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_miss   <= 1'b0;
      end
   end

   // R2: a result only appears after a sampled byte
   assert_valid_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid) |-> $past(byte_valid));
   // R3: a finished result holds until a new frame starts
   assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !(byte_valid && byte_sof) |=>
         res_valid && $stable(res_accept) && $stable(res_miss));
   // R7: a result without a miss is always accepted
   assert_hit_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_miss |-> res_accept);
   // R8: a one-byte frame reports a miss on the next cycle
   assert_short_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && byte_sof && byte_eof |=> res_valid && res_miss);
   // R9: a start byte that does not end the frame clears the result
   assert_sof_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && byte_sof && !byte_eof |=> !res_valid);
endmodule

// File: tb/eth_rx_addr_filter_tb.sv
module eth_rx_addr_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_valid = 1'b0, byte_sof = 1'b0, byte_eof = 1'b0;
   logic [7:0]  byte_data = '0;
   logic [15:0] stn_addr_hi = 16'h0211;
   logic [31:0] stn_addr_lo = 32'h2233_4455;
   logic [63:0] hash_tbl = '0;
   logic        mode_bcast_reject = 1'b0, mode_hash_all = 1'b0, mode_promisc = 1'b0;
   logic        res_valid, res_accept, res_miss;

   always #5 clk = ~clk;

   eth_rx_addr_filter dut_i (.*);

   typedef struct { logic acc; logic miss; int cnt; string tag; } exp_t;
   exp_t exp_q[$];

   int checks = 0, failures = 0;
   int frame_id = 0, checked_id = 0, sampled = 0;
   logic prev_v = 0, prev_s = 0;
   logic last_acc, last_miss;
   bit   finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [31:0] ref_crc(input logic [7:0] a [6]);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int n = 0; n < 6; n++)
         for (int b = 0; b < 8; b++) begin
            logic fb = c[31] ^ a[n][b];
            c = c << 1;
            if (fb) c ^= 32'h04C1_1DB7;
         end
      return c;
   endfunction

   function automatic logic [1:0] ref_eval(input logic [7:0] a [6], input int len);
      logic miss;
      if (len < 6) miss = 1;
      else if ({a[0],a[1],a[2],a[3],a[4],a[5]} == 48'hFFFF_FFFF_FFFF) miss = mode_bcast_reject;
      else if (a[0][0] || mode_hash_all) miss = !hash_tbl[ref_crc(a) >> 26];
      else miss = {a[0],a[1]} != stn_addr_hi || {a[2],a[3],a[4],a[5]} != stn_addr_lo;
      return {(!miss || mode_promisc), miss};
   endfunction

   task automatic drive(input logic v, input logic s, input logic e, input logic [7:0] d);
      @(posedge clk); #1;
      if (prev_v) begin
         if (prev_s) begin frame_id++; sampled = 1; end
         else sampled++;
      end
      prev_v = v; prev_s = s;
      byte_valid = v; byte_sof = s; byte_eof = e; byte_data = d;
   endtask

   // Sends len bytes of a frame; with push set, queues the expected result.
   task automatic send(input logic [7:0] a [6], input int len, input int gap,
                       input bit push, input bit with_eof, input string tag);
      logic [1:0] r;
      exp_t x;
      if (push) begin
         r = ref_eval(a, len);
         x.acc = r[1]; x.miss = r[0]; x.cnt = (len < 6) ? len : 6; x.tag = tag;
         exp_q.push_back(x);
      end
      for (int n = 0; n < len; n++) begin
         drive(1'b1, n == 0, with_eof && n == len - 1, (n < 6) ? a[n] : 8'(n * 17));
         if (gap > 0 && n % 2 == 1) repeat (gap) drive(1'b0, 1'b0, 1'b0, 8'h00);
      end
      drive(1'b0, 1'b0, 1'b0, 8'h00);
      drive(1'b0, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic expect_drained(input string tag);
      @(negedge clk);
      chk(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask

   // Monitor: compares each new result against the scoreboard queue.
   always @(negedge clk) begin
      if (rst_n && res_valid && frame_id != checked_id) begin
         exp_t x;
         checked_id = frame_id;
         if (exp_q.size() == 0) chk(0, "unexpected result", 1, 0);
         else begin
            x = exp_q.pop_front();
            chk(res_accept == x.acc, {x.tag, " accept"}, res_accept, x.acc);
            chk(res_miss == x.miss, {x.tag, " miss"}, res_miss, x.miss);
            chk(sampled == x.cnt, {x.tag, " timing R2"}, sampled, x.cnt);
         end
         last_acc = res_accept; last_miss = res_miss;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      logic [7:0] uni [6]     = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      logic [7:0] uni_bad5 [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56};
      logic [7:0] uni_bad0 [6] = '{8'h12, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      logic [7:0] bc [6]      = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
      logic [7:0] mc [6]      = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
      int mc_idx;

      #2;
      // R1: reset state
      chk(res_valid == 0 && res_accept == 0 && res_miss == 0, "R1 reset",
          {res_valid, res_accept, res_miss}, 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(res_valid == 0, "R1 after reset", res_valid, 0);

      // R3: bytes without a frame start are ignored
      drive(1'b1, 1'b0, 1'b0, 8'h02);
      drive(1'b0, 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      chk(res_valid == 0, "R3 stray byte", res_valid, 0);

      send(uni, 6, 0, 1, 1, "R6 unicast match");
      send(uni_bad5, 6, 0, 1, 1, "R6 mismatch byte5");
      send(uni_bad0, 6, 0, 1, 1, "R6 mismatch byte0");
      send(bc, 6, 0, 1, 1, "R4 broadcast allowed");
      mode_bcast_reject = 1'b1;
      send(bc, 6, 0, 1, 1, "R4 broadcast rejected");

      mc_idx = int'(ref_crc(mc) >> 26);
      hash_tbl = 64'd1 << mc_idx;
      send(mc, 6, 0, 1, 1, "R5 hash hit");
      hash_tbl = ~(64'd1 << mc_idx);
      send(mc, 6, 0, 1, 1, "R5 hash miss");
      mode_hash_all = 1'b1; hash_tbl = '0;
      send(uni, 6, 0, 1, 1, "R5 hash-all unicast miss");
      hash_tbl = 64'd1 << (ref_crc(uni) >> 26);
      send(uni, 6, 0, 1, 1, "R5 hash-all unicast hit");
      mode_hash_all = 1'b0;

      mode_promisc = 1'b1;
      send(uni_bad5, 6, 0, 1, 1, "R7 promisc keeps miss");
      send(uni, 6, 0, 1, 1, "R7 promisc hit");
      send(uni, 1, 0, 1, 1, "R8 one-byte promisc");
      mode_promisc = 1'b0;
      send(uni, 3, 0, 1, 1, "R8 short frame");

      send(uni, 6, 2, 1, 1, "R2 gapped bytes");
      send(uni_bad0, 12, 1, 1, 1, "R3 long frame");
      @(negedge clk);
      chk(res_valid && res_miss == last_miss && res_accept == last_acc,
          "R3 hold after trailing bytes", {res_valid, res_accept, res_miss},
          {1'b1, last_acc, last_miss});

      // R9: restart in the middle of a frame
      send(uni_bad0, 3, 0, 0, 0, "R9 aborted");
      @(negedge clk);
      chk(res_valid == 0, "R9 partial frame clears", res_valid, 0);
      send(uni, 6, 0, 1, 1, "R9 restarted frame");

      expect_drained("all results seen");
      finish_run();
   end
endmodule